// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a synchronous design read and write an external asynchronous static RAM of 128K bytes. A client raises a request with a direction flag, a 17-bit word address and a write byte while `ready` is high. The controller then selects the memory, holds the address for the whole access, times the active strobe for a fixed number of clock cycles and returns a one-clock `done` pulse. For reads, `done` comes with the captured byte.

The memory has one shared data bus. It is presented here as three split nets: drive value, drive enable and sampled input. The pad-level tri-state buffer sits outside the block. The memory is selected only when its active-low enable is low and its active-high enable is high. Between accesses the controller leaves the part deselected so that it powers down. The strobe length comes from two parameters, the access time in nanoseconds and the clock period.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and right after it, `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `ready`=1 and `done`=0.
- R2: While no access is in progress, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0) with both strobes high. `ready` is 1 only in that state.
- R3: From selection to deselection, `mem_addr` equals the address accepted with the request and does not change.
- R4: In a write, `mem_we_n` is low for exactly WAITS cycles and `mem_oe_n` stays high. `mem_dq_oe` is 1 with `mem_dq_out` equal to the accepted byte throughout that window and for one more cycle after `mem_we_n` returns high.
- R5: In a read, `mem_oe_n` is low for exactly WAITS cycles and `mem_dq_oe` stays 0. `rdata` equals the byte on `mem_dq_in` in the last cycle of that window.
- R6: Each accepted request produces exactly one `done` pulse, one clock wide. `ready` is 0 from the cycle after acceptance until the pulse has ended.
- R7: After a read, the cycle following `done` is deselected with `ready`=0, so the memory's outputs release the bus before any following write drives it.
- R8: WAITS = ceil(ACCESS_NS / CLK_NS), with a minimum of 1. The defaults of 55 ns and 4 ns give 14.
- R9: A request raised while `ready` is 0 is ignored. It starts no access and changes no memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, will accept a request |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | One-clock pulse at the end of each access |
| mem_addr | output | 17 | Address lines to the memory |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Enable for the bus drivers |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The bench models the memory and watches for bus contention, meaning the controller driving the bus while output enable is low. A design that dropped the data hold cycle, or let output enable overlap the write, would show up there. It counts strobe cycles against WAITS, so an off-by-one in the wait counter is caught. It issues read-then-write pairs to confirm the deselected turnaround cycle. It also holds a stray request across a busy access and reads the target address back: a controller that latches requests when not ready would corrupt that location.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 4,
  parameter int ACCESS_NS = 55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int WAITS_RAW = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int WAITS     = (WAITS_RAW < 1) ? 1 : WAITS_RAW;
  localparam int CW        = $clog2(WAITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          addr_q  <= addr;
          wr_q    <= wr;
          wdata_q <= wdata;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= CW'(WAITS - 1);
          st  <= S_STROBE;
        end
        S_STROBE: begin
          if (cnt == '0) begin
            if (!wr_q) rdata <= mem_dq_in;
            st <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD:  st <= wr_q ? S_IDLE : S_GAP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel        = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign ready      = (st == S_IDLE);
  assign done       = (st == S_HOLD);
  assign mem_addr   = addr_q;
  assign mem_ce1_n  = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = !((st == S_STROBE) && wr_q);
  assign mem_oe_n   = !((st == S_STROBE) && !wr_q);
  assign mem_dq_oe  = wr_q && ((st == S_STROBE) || (st == S_HOLD));
  assign mem_dq_out = wdata_q;

  p_idle_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_we_over_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce1_n) |-> mem_dq_oe);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_read_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_dq_oe) |=> (!ready && mem_ce1_n));
endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, wr = 0;
  logic [16:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic        ready, done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  int checks = 0, errors = 0;
  logic [7:0] mem    [logic [16:0]];
  logic [7:0] shadow [logic [16:0]];

  always #2 clk = ~clk;

  sram_ctl uut (.*);

  wire msel = !mem_ce1_n && mem_ce2;
  always @(posedge clk) if (msel && !mem_we_n) mem[mem_addr] = mem_dq_out;
  assign mem_dq_in = (msel && mem_we_n && !mem_oe_n) ?
                     (mem.exists(mem_addr) ? mem[mem_addr] : 8'h00) : 8'hzz;

  function automatic int exp_waits(input int acc, input int per);
    int w = (acc + per - 1) / per;
    return (w < 1) ? 1 : w;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [16:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [16:0] a, input logic [7:0] d,
                       input bit noise, input logic [16:0] na);
    int we_cnt = 0, oe_cnt = 0, guard = 0;
    bit sel_bad = 0, addr_bad = 0, dat_bad = 0, bus_bad = 0, rdy_bad = 0;
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; wr = 1'($urandom); addr = 17'($urandom); wdata = 8'($urandom);
    while (!done && guard < 200) begin
      if (noise) begin req = 1; wr = 1; addr = na; wdata = 8'h5A; end
      if (!msel) sel_bad = 1;
      if (mem_addr != a) addr_bad = 1;
      if (ready) rdy_bad = 1;
      if (!mem_we_n) begin
        we_cnt++;
        if (!mem_dq_oe || mem_dq_out != d || !mem_oe_n) dat_bad = 1;
      end
      if (!mem_oe_n) begin
        oe_cnt++;
        if (mem_dq_oe) bus_bad = 1;
      end
      @(negedge clk); guard++;
    end
    req = 0;
    chk(done, "R6 done seen", done, 1);
    chk(!sel_bad && msel, "R3 selected during access", sel_bad, 0);
    chk(!addr_bad && mem_addr == a, "R3 address held", mem_addr, a);
    chk(!rdy_bad && !ready, "R6 ready low while busy", rdy_bad, 0);
    if (w) begin
      chk(we_cnt == exp_waits(55, 4), "R8 R4 write strobe length", we_cnt, exp_waits(55, 4));
      chk(oe_cnt == 0 && !dat_bad, "R4 write data and oe", dat_bad, 0);
      chk(mem_we_n && mem_dq_oe && mem_dq_out == d, "R4 data held after we", mem_dq_oe, 1);
      shadow[a] = d;
    end else begin
      chk(oe_cnt == exp_waits(55, 4), "R8 R5 read strobe length", oe_cnt, exp_waits(55, 4));
      chk(we_cnt == 0 && !bus_bad && !mem_dq_oe, "R5 no drive in read", bus_bad, 0);
      chk(rdata == exp_byte(a), "R5 read data", rdata, exp_byte(a));
    end
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n, "R2 deselect after access", mem_ce1_n, 1);
    if (w) chk(ready, "R2 ready after write", ready, 1);
    else   chk(!ready && !mem_dq_oe, "R7 turnaround gap", ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !done,
        "R1 reset strobes", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    rst_n = 1;
    @(negedge clk);
    chk(ready && !done && mem_ce1_n && !mem_ce2, "R1 R2 idle after reset", ready, 1);

    do_op(1, 17'h00000, 8'hA5, 0, 0);
    do_op(1, 17'h1FFFF, 8'h3C, 0, 0);
    do_op(0, 17'h00000, 8'h00, 0, 0);
    do_op(1, 17'h00010, 8'hC3, 0, 0);
    do_op(0, 17'h1FFFF, 8'h00, 0, 0);
    do_op(1, 17'h00001, 8'h77, 0, 0);
    do_op(0, 17'h00001, 8'h00, 0, 0);
    do_op(1, 17'h00002, 8'hFF, 1, 17'h00010);
    repeat (3) @(negedge clk);
    chk(mem_ce1_n && ready, "R9 stray request ignored", mem_ce1_n, 1);
    do_op(0, 17'h00010, 8'h00, 0, 0);
    do_op(0, 17'h00002, 8'h00, 1, 17'h00000);
    do_op(0, 17'h00000, 8'h00, 0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [16:0] a = ($urandom % 4 == 0) ? 17'($urandom) : 17'($urandom % 16);
      do_op(1'($urandom), a, 8'($urandom), 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule